// File: doc/BRIEF.md
# RGB 8-bit / Half-Precision Pixel Converter

This block holds two independent streaming converters for RGB pixels. The forward converter takes pixels with three 8-bit channels. It turns each channel into an IEEE half-precision value scaled so that 0 maps to 0.0 and 255 maps to 1.0. Later arithmetic stages then work where float16 has most of its precision. The reverse converter takes three half-precision channels and turns each one back into an 8-bit code. It rounds to the nearest code and clamps anything at or above 1.0 to full scale.

Each direction is built from one single-channel lane that a generate loop places three times. A small flow controller drives the lanes, moving a valid / ready (stb/ack) handshake with start-of-packet and end-of-packet markers through the same two register stages as the data. A parameter picks how the forward lane is built. It can use leading-one detection with normalisation arithmetic, or a 256-entry table that is computed when the design is elaborated. Both builds give the same results.

Top module: `rgb_half_conv`

## Requirements
- R1: For each forward channel value v, the result is the nearest float16 to v/255, with ties impossible. 0 gives 16'h0000 and 255 gives exactly 16'h3C00. No result has the sign bit set or exceeds 16'h3C00.
- R2: In both directions, a pixel accepted on a clock edge (stb_i and ack_o high) appears on stb_o after the second following edge, provided the output register was free on the edge in between.
- R3: For a reverse channel with sign 0 and a value below 1.0 (subnormals included), the result is floor(value*255 + 0.5). For example, 16'h3800 (0.5) gives 128.
- R4: A reverse channel with sign 0 and a value of 1.0 or more gives 255. This covers every exponent field of 15 to 30 and +infinity (16'h7C00). The result never wraps.
- R5: A reverse channel with the sign bit set gives 0. This covers -0.0, negative values and negative infinity. Any NaN (exponent field 31 with a nonzero fraction) also gives 0.
- R6: The three channels convert independently. The 8-bit pixel packs b in bits [7:0], g in [15:8] and r in [23:16]. The half pixel packs b in [15:0], g in [31:16] and r in [47:32].
- R7: sop_o and eop_o leave together with the pixel they entered with. They are never high while stb_o is low.
- R8: While stb_o is high and ack_i is low, the output pixel and its markers hold steady and no pixel is lost or duplicated.
- R9: With USE_LUT set, the forward path gives output bit-identical to the arithmetic build, with identical timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fwd_stb_i | input | 1 | Forward input pixel valid |
| fwd_ack_o | output | 1 | Forward input accepted |
| fwd_sop_i | input | 1 | Forward input start of packet |
| fwd_eop_i | input | 1 | Forward input end of packet |
| fwd_pix_i | input | 24 | 8-bit RGB pixel in |
| fwd_stb_o | output | 1 | Forward output valid |
| fwd_ack_i | input | 1 | Forward output ready |
| fwd_sop_o | output | 1 | Forward output start of packet |
| fwd_eop_o | output | 1 | Forward output end of packet |
| fwd_pix_o | output | 48 | Half-precision RGB pixel out |
| rev_stb_i | input | 1 | Reverse input pixel valid |
| rev_ack_o | output | 1 | Reverse input accepted |
| rev_sop_i | input | 1 | Reverse input start of packet |
| rev_eop_i | input | 1 | Reverse input end of packet |
| rev_pix_i | input | 48 | Half-precision RGB pixel in |
| rev_stb_o | output | 1 | Reverse output valid |
| rev_ack_i | input | 1 | Reverse output ready |
| rev_sop_o | output | 1 | Reverse output start of packet |
| rev_eop_o | output | 1 | Reverse output end of packet |
| rev_pix_o | output | 24 | 8-bit RGB pixel out |

## Verification
The assertions check the following on every cycle:
- the two-cycle latency of the handshake;
- that markers travel only with valid data;
- that the handshake and lane registers hold while the output is stalled;
- the fixed end points of the forward mapping and its bound of 1.0;
- saturation to 255 and forcing to 0 for the special classes of reverse input.

The correctness of each rounded code, and the independence and packing of the channels, come only from the bench sweeps. These cover every 8-bit value in the forward direction and all 65536 half-precision patterns in the reverse direction, under irregular valid and ready patterns. Agreement between the table build and the arithmetic build is also shown only by running both side by side.

// File: rtl/rgb_half_pkg.sv
package rgb_half_pkg;
  localparam int unsigned PIPE_DEPTH = 2;
  localparam int unsigned LANES      = 3;
  localparam int unsigned NARROW_W   = 8;
  localparam int unsigned HALF_W     = 16;

  typedef enum logic [1:0] {CLS_ZERO, CLS_CALC, CLS_SAT} rev_cls_e;

  function automatic logic [2:0] lead_one(input logic [7:0] v);
    logic [2:0] p;
    p = 3'd0;
    for (int i = 0; i < 8; i++) if (v[i]) p = 3'(i);
    return p;
  endfunction

  // n has its msb set; rounds 2048*n/255 = 8n + 8n/255, divide via (y+1+(y>>8))>>8
  function automatic logic [15:0] half_from_norm(input logic [7:0] n, input logic [2:0] p);
    logic [11:0] base, y, t, f;
    base = {1'b0, n, 3'b000};
    y    = base + 12'd127;
    t    = y + 12'd1 + {8'd0, y[11:8]};
    f    = base + {8'd0, t[11:8]};
    if (f[11]) return {1'b0, 5'(p) + 5'd8, 10'd0};
    return {1'b0, 5'(p) + 5'd7, f[9:0]};
  endfunction

  function automatic logic [15:0] u8_to_half(input logic [7:0] v);
    logic [2:0] p;
    p = lead_one(v);
    if (v == 8'd0) return 16'h0000;
    return half_from_norm(8'(v << (3'd7 - p)), p);
  endfunction
endpackage

// File: rtl/rgb_half_flow.sv
module rgb_half_flow #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic sop_i,
  input  logic eop_i,
  output logic ack_o,
  output logic stb_o,
  output logic sop_o,
  output logic eop_o,
  input  logic ack_i,
  output logic adv_o
);
  logic [DEPTH-1:0] vld_q, sop_q, eop_q;

  assign adv_o = ~vld_q[DEPTH-1] | ack_i;
  assign ack_o = adv_o;
  assign stb_o = vld_q[DEPTH-1];
  assign sop_o = sop_q[DEPTH-1];
  assign eop_o = eop_q[DEPTH-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      sop_q <= '0;
      eop_q <= '0;
    end else if (adv_o) begin
      vld_q <= {vld_q[DEPTH-2:0], stb_i};
      sop_q <= {sop_q[DEPTH-2:0], stb_i & sop_i};
      eop_q <= {eop_q[DEPTH-2:0], stb_i & eop_i};
    end
  end

  p_marker_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sop_o || eop_o) |-> stb_o);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_o && !ack_i) |=> (stb_o && $stable(sop_o) && $stable(eop_o)));

  if (DEPTH == 2) begin : g_lat
    p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stb_i && ack_o) ##1 adv_o |=> stb_o);
  end
endmodule

// File: rtl/rgb_half_fwd_lane.sv
module rgb_half_fwd_lane
  import rgb_half_pkg::*;
#(
  parameter bit USE_LUT = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                adv_i,
  input  logic [NARROW_W-1:0] v_i,
  output logic [HALF_W-1:0]   out_o
);
  if (USE_LUT) begin : g_lut
    localparam int unsigned ENTRIES = 1 << NARROW_W;
    logic [HALF_W-1:0]   lut [ENTRIES];
    logic [NARROW_W-1:0] v_q;
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      assign lut[i] = u8_to_half(NARROW_W'(i));
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q   <= '0;
        out_o <= '0;
      end else if (adv_i) begin
        v_q   <= v_i;
        out_o <= lut[v_q];
      end
    end
  end else begin : g_arith
    logic [2:0]          p_d, p_q;
    logic [NARROW_W-1:0] n_q;
    logic                zero_q;
    assign p_d = lead_one(v_i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        p_q    <= '0;
        n_q    <= '0;
        zero_q <= 1'b1;
        out_o  <= '0;
      end else if (adv_i) begin
        p_q    <= p_d;
        n_q    <= NARROW_W'(v_i << (3'd7 - p_d));
        zero_q <= (v_i == '0);
        out_o  <= zero_q ? '0 : half_from_norm(n_q, p_q);
      end
    end
  end

  p_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_o <= 16'h3C00);
  p_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && v_i == 8'd0) ##1 adv_i |=> out_o == 16'h0000);
  p_one_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && v_i == 8'd255) ##1 adv_i |=> out_o == 16'h3C00);
  p_hold_fwd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(out_o));
endmodule

// File: rtl/rgb_half_rev_lane.sv
module rgb_half_rev_lane
  import rgb_half_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                adv_i,
  input  logic [HALF_W-1:0]   h_i,
  output logic [NARROW_W-1:0] out_o
);
  logic [4:0]  e;
  logic [9:0]  m;
  logic [10:0] sig;
  logic [4:0]  ee;
  rev_cls_e    cls_d, cls_q;
  logic [18:0] prod_q;
  logic [4:0]  sh_q;
  logic [24:0] acc;

  assign e   = h_i[14:10];
  assign m   = h_i[9:0];
  assign sig = (e == 5'd0) ? {1'b0, m} : {1'b1, m};
  assign ee  = (e == 5'd0) ? 5'd1 : e;

  always_comb begin
    if (h_i[15] || (e == 5'd31 && m != 10'd0)) cls_d = CLS_ZERO;
    else if (e >= 5'd15)                       cls_d = CLS_SAT;
    else                                       cls_d = CLS_CALC;
  end

  // value*255 = sig*255 * 2^(ee-25); round half up
  assign acc = {6'd0, prod_q} + (25'd1 << (sh_q - 5'd1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cls_q  <= CLS_ZERO;
      prod_q <= '0;
      sh_q   <= 5'd24;
      out_o  <= '0;
    end else if (adv_i) begin
      cls_q  <= cls_d;
      prod_q <= ({8'd0, sig} << 8) - {8'd0, sig};
      sh_q   <= 5'd25 - ee;
      case (cls_q)
        CLS_SAT:  out_o <= 8'hff;
        CLS_CALC: out_o <= 8'(acc >> sh_q);
        default:  out_o <= 8'h00;
      endcase
    end
  end

  p_sat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !h_i[15] && h_i[14:10] >= 5'd15 && !(h_i[14:10] == 5'd31 && h_i[9:0] != 10'd0))
    ##1 adv_i |=> out_o == 8'hff);
  p_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && (h_i[15] || (h_i[14:10] == 5'd31 && h_i[9:0] != 10'd0)))
    ##1 adv_i |=> out_o == 8'h00);
  p_hold_rev_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(out_o));
endmodule

// File: rtl/rgb_half_conv.sv
module rgb_half_conv
  import rgb_half_pkg::*;
#(
  parameter bit USE_LUT = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        fwd_stb_i,
  output logic        fwd_ack_o,
  input  logic        fwd_sop_i,
  input  logic        fwd_eop_i,
  input  logic [23:0] fwd_pix_i,
  output logic        fwd_stb_o,
  input  logic        fwd_ack_i,
  output logic        fwd_sop_o,
  output logic        fwd_eop_o,
  output logic [47:0] fwd_pix_o,
  input  logic        rev_stb_i,
  output logic        rev_ack_o,
  input  logic        rev_sop_i,
  input  logic        rev_eop_i,
  input  logic [47:0] rev_pix_i,
  output logic        rev_stb_o,
  input  logic        rev_ack_i,
  output logic        rev_sop_o,
  output logic        rev_eop_o,
  output logic [23:0] rev_pix_o
);
  logic fwd_adv, rev_adv;

  rgb_half_flow #(.DEPTH(PIPE_DEPTH)) u_fwd_flow (
    .clk_i, .rst_ni,
    .stb_i(fwd_stb_i), .sop_i(fwd_sop_i), .eop_i(fwd_eop_i), .ack_o(fwd_ack_o),
    .stb_o(fwd_stb_o), .sop_o(fwd_sop_o), .eop_o(fwd_eop_o), .ack_i(fwd_ack_i),
    .adv_o(fwd_adv)
  );

  rgb_half_flow #(.DEPTH(PIPE_DEPTH)) u_rev_flow (
    .clk_i, .rst_ni,
    .stb_i(rev_stb_i), .sop_i(rev_sop_i), .eop_i(rev_eop_i), .ack_o(rev_ack_o),
    .stb_o(rev_stb_o), .sop_o(rev_sop_o), .eop_o(rev_eop_o), .ack_i(rev_ack_i),
    .adv_o(rev_adv)
  );

  for (genvar c = 0; c < LANES; c++) begin : g_chan
    rgb_half_fwd_lane #(.USE_LUT(USE_LUT)) u_fwd (
      .clk_i, .rst_ni, .adv_i(fwd_adv),
      .v_i  (fwd_pix_i[c*NARROW_W +: NARROW_W]),
      .out_o(fwd_pix_o[c*HALF_W +: HALF_W])
    );
    rgb_half_rev_lane u_rev (
      .clk_i, .rst_ni, .adv_i(rev_adv),
      .h_i  (rev_pix_i[c*HALF_W +: HALF_W]),
      .out_o(rev_pix_o[c*NARROW_W +: NARROW_W])
    );
  end
endmodule

// File: tb/rgb_half_conv_bench.sv
module rgb_half_conv_bench;
  localparam int N_F = 1024;
  localparam int N_R = 65536;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        fwd_stb_i = 0, fwd_sop_i = 0, fwd_eop_i = 0, fwd_ack_i = 1;
  logic [23:0] fwd_pix_i = '0;
  logic        rev_stb_i = 0, rev_sop_i = 0, rev_eop_i = 0, rev_ack_i = 1;
  logic [47:0] rev_pix_i = '0;
  logic        fwd_ack_o, fwd_stb_o, fwd_sop_o, fwd_eop_o;
  logic [47:0] fwd_pix_o;
  logic        rev_ack_o, rev_stb_o, rev_sop_o, rev_eop_o;
  logic [23:0] rev_pix_o;
  logic        l_fwd_ack_o, l_fwd_stb_o, l_fwd_sop_o, l_fwd_eop_o;
  logic [47:0] l_fwd_pix_o;
  logic        l_rev_ack_o, l_rev_stb_o, l_rev_sop_o, l_rev_eop_o;
  logic [23:0] l_rev_pix_o;

  rgb_half_conv u_rgb_half_conv (
    .clk_i(clk), .rst_ni(rst_n),
    .fwd_stb_i, .fwd_ack_o, .fwd_sop_i, .fwd_eop_i, .fwd_pix_i,
    .fwd_stb_o, .fwd_ack_i, .fwd_sop_o, .fwd_eop_o, .fwd_pix_o,
    .rev_stb_i, .rev_ack_o, .rev_sop_i, .rev_eop_i, .rev_pix_i,
    .rev_stb_o, .rev_ack_i, .rev_sop_o, .rev_eop_o, .rev_pix_o
  );

  rgb_half_conv #(.USE_LUT(1'b1)) u_rgb_half_conv_lut (
    .clk_i(clk), .rst_ni(rst_n),
    .fwd_stb_i, .fwd_ack_o(l_fwd_ack_o), .fwd_sop_i, .fwd_eop_i, .fwd_pix_i,
    .fwd_stb_o(l_fwd_stb_o), .fwd_ack_i, .fwd_sop_o(l_fwd_sop_o), .fwd_eop_o(l_fwd_eop_o),
    .fwd_pix_o(l_fwd_pix_o),
    .rev_stb_i, .rev_ack_o(l_rev_ack_o), .rev_sop_i, .rev_eop_i, .rev_pix_i,
    .rev_stb_o(l_rev_stb_o), .rev_ack_i, .rev_sop_o(l_rev_sop_o), .rev_eop_o(l_rev_eop_o),
    .rev_pix_o(l_rev_pix_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_half(input int v);
    real s;
    int  e, mi;
    if (v == 0) return 16'h0000;
    s = real'(v) / 255.0;
    e = 0;
    while (s < 1.0) begin s = s * 2.0; e--; end
    mi = $rtoi((s - 1.0) * 1024.0 + 0.5);
    if (mi == 1024) begin mi = 0; e++; end
    return {1'b0, 5'(e + 15), 10'(mi)};
  endfunction

  function automatic logic [7:0] ref_byte(input logic [15:0] h);
    int  e, m, k;
    real val;
    e = int'(h[14:10]);
    m = int'(h[9:0]);
    if (e == 31) return (h[15] || m != 0) ? 8'd0 : 8'd255;
    if (h[15]) return 8'd0;
    if (e >= 15) return 8'd255;
    val = (e == 0) ? real'(m) : real'(m + 1024);
    k   = (e == 0) ? 24 : 25 - e;
    for (int i = 0; i < k; i++) val = val * 0.5;
    return 8'($rtoi(val * 255.0 + 0.5));
  endfunction

  function automatic string rev_tag(input logic [15:0] h);
    if (h[15] || (h[14:10] == 5'd31 && h[9:0] != 0)) return "R5";
    if (h[14:10] >= 5'd15) return "R4";
    return "R3";
  endfunction

  function automatic logic [23:0] fwd_stim(input int k);
    return {8'(k), 8'(255 - k), 8'(k * 37 + 11)};
  endfunction
  function automatic logic [47:0] rev_stim(input int k);
    return {16'(k), ~16'(k), 16'(k) ^ 16'h3C00};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    int fi = 0, fo = 0, ri = 0, ro = 0, cyc = 0;
    bit f_stall = 0, r_stall = 0;
    logic [49:0] f_held = '0;
    logic [25:0] r_held = '0;
    logic [47:0] ef;
    logic [23:0] er;

    repeat (3) @(negedge clk);
    chk(fwd_stb_o == 0 && rev_stb_o == 0, "R2", "reset stb_o", {46'd0, fwd_stb_o, rev_stb_o}, 48'd0);
    chk(fwd_pix_o == 0 && rev_pix_o == 0, "R1", "reset pix", fwd_pix_o, 48'd0);
    rst_n = 1'b1;

    // directed latency and boundary pixels
    @(negedge clk);
    fwd_stb_i = 1; fwd_sop_i = 1; fwd_eop_i = 1; fwd_pix_i = {8'd255, 8'd0, 8'd1};
    rev_stb_i = 1; rev_sop_i = 1; rev_eop_i = 1; rev_pix_i = {16'h3C00, 16'h3800, 16'h7E00};
    @(negedge clk);
    fwd_stb_i = 0; rev_stb_i = 0;
    chk(fwd_stb_o == 0, "R2", "fwd stb after one edge", {47'd0, fwd_stb_o}, 48'd0);
    chk(rev_stb_o == 0, "R2", "rev stb after one edge", {47'd0, rev_stb_o}, 48'd0);
    @(negedge clk);
    chk(fwd_stb_o == 1 && rev_stb_o == 1, "R2", "stb after two edges", {46'd0, fwd_stb_o, rev_stb_o}, 48'd3);
    chk(fwd_pix_o == {16'h3C00, 16'h0000, ref_half(1)}, "R1", "fwd end points",
        fwd_pix_o, {16'h3C00, 16'h0000, ref_half(1)});
    chk(rev_pix_o == {8'd255, 8'd128, 8'd0}, "R3", "rev 1.0/0.5/NaN", {24'd0, rev_pix_o}, {24'd0, 8'd255, 8'd128, 8'd0});
    chk(fwd_sop_o && fwd_eop_o && rev_sop_o && rev_eop_o, "R7", "markers with pixel",
        {44'd0, fwd_sop_o, fwd_eop_o, rev_sop_o, rev_eop_o}, 48'hf);
    @(negedge clk);
    chk(fwd_stb_o == 0 && rev_stb_o == 0, "R8", "drained once", {46'd0, fwd_stb_o, rev_stb_o}, 48'd0);

    // streaming sweeps with irregular valid / ready
    while (fo < N_F || ro < N_R) begin
      @(negedge clk);
      cyc++;
      fwd_stb_i = (fi < N_F) && (cyc % 7 != 3);
      fwd_pix_i = fwd_stim(fi);
      fwd_sop_i = (fi % 64 == 0);
      fwd_eop_i = (fi % 64 == 63);
      fwd_ack_i = (cyc % 5 != 2);
      rev_stb_i = (ri < N_R) && (cyc % 6 != 4);
      rev_pix_i = rev_stim(ri);
      rev_sop_i = (ri % 64 == 0);
      rev_eop_i = (ri % 64 == 63);
      rev_ack_i = (cyc % 4 != 1);
      #1;
      if (f_stall)
        chk(fwd_stb_o && {fwd_sop_o, fwd_eop_o, fwd_pix_o} == f_held, "R8", "fwd held while stalled",
            {fwd_pix_o}, f_held[47:0]);
      if (r_stall)
        chk(rev_stb_o && {rev_sop_o, rev_eop_o, rev_pix_o} == r_held, "R8", "rev held while stalled",
            {24'd0, rev_pix_o}, {24'd0, r_held[23:0]});
      if (fwd_stb_o) begin
        chk(l_fwd_stb_o && l_fwd_pix_o == fwd_pix_o && l_fwd_sop_o == fwd_sop_o && l_fwd_eop_o == fwd_eop_o,
            "R9", "table build vs arithmetic build", l_fwd_pix_o, fwd_pix_o);
      end
      if (fwd_stb_o && fwd_ack_i) begin
        ef = {ref_half(int'(fwd_stim(fo)[23:16])), ref_half(int'(fwd_stim(fo)[15:8])),
              ref_half(int'(fwd_stim(fo)[7:0]))};
        chk(fwd_pix_o[47:32] == ef[47:32], "R1", "fwd r channel", fwd_pix_o, ef);
        chk(fwd_pix_o[31:0] == ef[31:0], "R6", "fwd g/b channels", fwd_pix_o, ef);
        chk(fwd_sop_o == (fo % 64 == 0) && fwd_eop_o == (fo % 64 == 63), "R7", "fwd markers",
            {46'd0, fwd_sop_o, fwd_eop_o}, {46'd0, fo % 64 == 0, fo % 64 == 63});
        fo++;
      end
      if (rev_stb_o && rev_ack_i) begin
        er = {ref_byte(rev_stim(ro)[47:32]), ref_byte(rev_stim(ro)[31:16]), ref_byte(rev_stim(ro)[15:0])};
        chk(rev_pix_o[23:16] == er[23:16], rev_tag(rev_stim(ro)[47:32]), "rev r channel",
            {24'd0, rev_pix_o}, {24'd0, er});
        chk(rev_pix_o[15:0] == er[15:0], "R6", "rev g/b channels", {24'd0, rev_pix_o}, {24'd0, er});
        chk(rev_sop_o == (ro % 64 == 0) && rev_eop_o == (ro % 64 == 63), "R7", "rev markers",
            {46'd0, rev_sop_o, rev_eop_o}, {46'd0, ro % 64 == 0, ro % 64 == 63});
        ro++;
      end
      f_stall = fwd_stb_o && !fwd_ack_i;
      f_held  = {fwd_sop_o, fwd_eop_o, fwd_pix_o};
      r_stall = rev_stb_o && !rev_ack_i;
      r_held  = {rev_sop_o, rev_eop_o, rev_pix_o};
      if (fwd_stb_i && fwd_ack_o) fi++;
      if (rev_stb_i && rev_ack_o) ri++;
    end

    @(negedge clk);
    fwd_stb_i = 0; rev_stb_i = 0; fwd_ack_i = 1; rev_ack_i = 1;
    repeat (3) @(negedge clk);
    chk(fwd_stb_o == 0 && rev_stb_o == 0, "R8", "no extra pixels", {46'd0, fwd_stb_o, rev_stb_o}, 48'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule